// File: doc/BRIEF.md
# Four-Valued Digit Adder from Literal Gates

This block adds two four-valued digits and returns a sum digit and a carry digit, so that the value of the inputs added together equals four times the carry plus the sum. Each digit travels on a two-bit wire as a plain binary code for the levels 0 to 3.

The arithmetic is not built from binary full-adder logic. It is built only from multi-valued primitives:

- Every input drives a bank of disjoint literal gates. Each gate answers "is this input equal to level i" with either the top level or zero.
- For each input pair that gives a non-zero output, the two matching literals are combined by a minimum (the four-valued AND), together with the output level as a constant.
- For each output, all of these product terms are merged by a maximum (the four-valued OR).

Input pairs whose output digit is zero contribute no product term. A product term whose output level is the top level carries no constant, because taking the minimum with the top level changes nothing.

The literal, product and merge stages are combinational. The two result digits are captured in a register with a synchronous, active-high reset, so a result appears one clock after its operands are sampled.

Top module: `qv_adder`

## Requirements
- R1: Each digit on `a`, `b`, `s` and `k` is a two-bit code whose unsigned binary value is the level: 00 is 0, 01 is 1, 10 is 2 and 11 is 3.
- R2: For each input, the literal gate for level i outputs 3 when the input equals i and outputs 0 otherwise, so exactly one of the four literals of an input is at level 3.
- R3: The carry digit `k` is never above 1, because every carry product term carries the constant level 1 and the merge takes the maximum.
- R4: For every one of the 16 operand pairs, `s` equals (a+b) mod 4 and `k` equals (a+b) div 4.
- R5: `k` is 1 exactly for the operand pairs (1,3), (2,2), (2,3), (3,1), (3,2) and (3,3), and is 0 for the other ten pairs.
- R6: The result for the operands present at a rising clock edge appears on `s` and `k` after that edge and is held until the next edge.
- R7: While `rst` is high at a rising edge, `s` and `k` become 0, whatever the operands are.
- R8: The corner pairs give these results: 3+3 gives k=1 and s=2; 2+2 gives k=1 and s=0; 0+0 gives k=0 and s=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; results are captured on the rising edge |
| rst | input | 1 | Synchronous active-high reset of the result register |
| a | input | 2 | First operand digit, level 0 to 3 |
| b | input | 2 | Second operand digit, level 0 to 3 |
| s | output | 2 | Registered sum digit |
| k | output | 2 | Registered carry digit, level 0 or 1 |

## Verification
The situation hardest to reach from the ports is a fault in a single product term. Each term is live for only one of the sixteen operand pairs, and its effect is hidden under the maximum taken with all the other terms. For that reason the stimulus walks all sixteen pairs back to back, so that every product term is the one that sets the output in exactly one cycle.

The pairs 3+3 and 2+2 are then driven again on their own, since they are the cases where a wrong constant level or a dropped constant shows up first. A reset applied while the operands are 3 and 3 shows that the reset clears the register ahead of the largest result.

// File: rtl/qv_pkg.sv
package qv_pkg;

  // Which digit of the result a product plane builds.
  typedef enum logic {
    QV_OUT_SUM   = 1'b0,
    QV_OUT_CARRY = 1'b1
  } qv_out_e;

  // Truth-table value of the sum digit for one operand pair.
  function automatic int qv_sum_level(input int x, input int y, input int levels);
    return (x + y) % levels;
  endfunction

  // Truth-table value of the carry digit for one operand pair.
  function automatic int qv_carry_level(input int x, input int y, input int levels);
    return (x + y) / levels;
  endfunction

  // Truth-table entry for the selected output digit.
  function automatic int qv_table_level(input qv_out_e sel, input int x, input int y,
                                        input int levels);
    if (sel == QV_OUT_SUM) return qv_sum_level(x, y, levels);
    return qv_carry_level(x, y, levels);
  endfunction

endpackage

// File: rtl/qv_literal_bank.sv
// Disjoint literal gates: slice i is the top level when x == i, else zero.
module qv_literal_bank #(
  parameter int LEVELS = 4,
  parameter int W      = $clog2(LEVELS)
) (
  input  logic [W-1:0]        x,
  output logic [LEVELS*W-1:0] lit
);
  localparam logic [W-1:0] TOP = W'(LEVELS - 1);

  for (genvar i = 0; i < LEVELS; i++) begin : g_lit
    assign lit[i*W +: W] = (x == W'(i)) ? TOP : '0;
  end
endmodule

// File: rtl/qv_term_plane.sv
// One minimum-product per non-zero truth-table row of the chosen output.
module qv_term_plane
  import qv_pkg::*;
#(
  parameter int      LEVELS = 4,
  parameter int      W      = $clog2(LEVELS),
  parameter qv_out_e SEL    = QV_OUT_SUM
) (
  input  logic [LEVELS*W-1:0]        lit_a,
  input  logic [LEVELS*W-1:0]        lit_b,
  output logic [LEVELS*LEVELS*W-1:0] terms
);
  function automatic logic [W-1:0] qmin(input logic [W-1:0] p, input logic [W-1:0] q);
    return (p < q) ? p : q;
  endfunction

  for (genvar i = 0; i < LEVELS; i++) begin : g_row
    for (genvar j = 0; j < LEVELS; j++) begin : g_col
      localparam int E   = qv_table_level(SEL, i, j, LEVELS);
      localparam int IDX = i * LEVELS + j;

      if (E == 0) begin : g_none
        // A zero row contributes no product term.
        assign terms[IDX*W +: W] = '0;
      end else if (E == LEVELS - 1) begin : g_top
        // Minimum with the top level is the identity, so the constant is dropped.
        assign terms[IDX*W +: W] = qmin(lit_a[i*W +: W], lit_b[j*W +: W]);
      end else begin : g_lvl
        assign terms[IDX*W +: W] =
          qmin(qmin(lit_a[i*W +: W], lit_b[j*W +: W]), W'(E));
      end
    end
  end
endmodule

// File: rtl/qv_max_merge.sv
// Maximum (four-valued OR) over N packed W-bit terms.
module qv_max_merge #(
  parameter int N = 16,
  parameter int W = 2
) (
  input  logic [N*W-1:0] terms,
  output logic [W-1:0]   y
);
  always_comb begin
    y = '0;
    for (int t = 0; t < N; t++) begin
      if (terms[t*W +: W] > y) y = terms[t*W +: W];
    end
  end
endmodule

// File: rtl/qv_adder.sv
module qv_adder
  import qv_pkg::*;
#(
  parameter int LEVELS = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [$clog2(LEVELS)-1:0] a,
  input  logic [$clog2(LEVELS)-1:0] b,
  output logic [$clog2(LEVELS)-1:0] s,
  output logic [$clog2(LEVELS)-1:0] k
);
  localparam int W = $clog2(LEVELS);
  localparam int N = LEVELS * LEVELS;

  logic [LEVELS*W-1:0] lit_a;
  logic [LEVELS*W-1:0] lit_b;
  logic [N*W-1:0]      sum_terms;
  logic [N*W-1:0]      car_terms;
  logic [W-1:0]        sum_lvl;
  logic [W-1:0]        car_lvl;

  qv_literal_bank #(.LEVELS(LEVELS), .W(W)) u_lit_a (.x(a), .lit(lit_a));
  qv_literal_bank #(.LEVELS(LEVELS), .W(W)) u_lit_b (.x(b), .lit(lit_b));

  qv_term_plane #(.LEVELS(LEVELS), .W(W), .SEL(QV_OUT_SUM)) u_sum_plane (
    .lit_a(lit_a), .lit_b(lit_b), .terms(sum_terms)
  );
  qv_term_plane #(.LEVELS(LEVELS), .W(W), .SEL(QV_OUT_CARRY)) u_car_plane (
    .lit_a(lit_a), .lit_b(lit_b), .terms(car_terms)
  );

  qv_max_merge #(.N(N), .W(W)) u_sum_merge (.terms(sum_terms), .y(sum_lvl));
  qv_max_merge #(.N(N), .W(W)) u_car_merge (.terms(car_terms), .y(car_lvl));

  always_ff @(posedge clk) begin
    if (rst) begin
      s <= '0;
      k <= '0;
    end else begin
      s <= sum_lvl;
      k <= car_lvl;
    end
  end
endmodule

// File: rtl/qv_adder_chk.sv
module qv_adder_chk #(
  parameter int LEVELS = 4,
  parameter int W      = 2
) (
  input logic                clk,
  input logic                rst,
  input logic [W-1:0]        a,
  input logic [W-1:0]        b,
  input logic [W-1:0]        s,
  input logic [W-1:0]        k,
  input logic [LEVELS*W-1:0] lit_a,
  input logic [LEVELS*W-1:0] lit_b
);
  localparam logic [W-1:0] TOP = W'(LEVELS - 1);

  logic [LEVELS-1:0] hit_a, hit_b, ok_a, ok_b;
  logic [W:0]        tot;

  for (genvar i = 0; i < LEVELS; i++) begin : g_lv
    assign hit_a[i] = (lit_a[i*W +: W] == TOP);
    assign hit_b[i] = (lit_b[i*W +: W] == TOP);
    assign ok_a[i]  = hit_a[i] || (lit_a[i*W +: W] == '0);
    assign ok_b[i]  = hit_b[i] || (lit_b[i*W +: W] == '0);
  end

  assign tot = {1'b0, a} + {1'b0, b};

  // R2: one literal per input at the top level, at the input's index, the rest at zero
  assert_literal_onehot_R2: assert property (@(posedge clk) disable iff (rst)
    ($countones(hit_a) == 1) && hit_a[a] && (&ok_a) &&
    ($countones(hit_b) == 1) && hit_b[b] && (&ok_b));

  // R3: carry digit never exceeds 1
  assert_carry_max_R3: assert property (@(posedge clk) disable iff (rst)
    k <= W'(1));

  // R4 / R6: sum digit one clock after the operands
  assert_sum_digit_R4: assert property (@(posedge clk) disable iff (rst)
    !rst |=> s == $past(tot[W-1:0]));

  // R5 / R6: carry digit one clock after the operands
  assert_carry_digit_R5: assert property (@(posedge clk) disable iff (rst)
    !rst |=> k == W'($past(tot[W])));

  // R7: synchronous reset clears both digits
  assert_reset_clear_R7: assert property (@(posedge clk)
    rst |=> (s == '0) && (k == '0));
endmodule

bind qv_adder qv_adder_chk #(.LEVELS(LEVELS), .W(W)) u_chk (
  .clk(clk), .rst(rst), .a(a), .b(b), .s(s), .k(k),
  .lit_a(lit_a), .lit_b(lit_b)
);

// File: tb/qv_adder_test.sv
`timescale 1ns/1ps
module qv_adder_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] a = '0;
  logic [1:0] b = '0;
  logic [1:0] s, k;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [1:0] q_s[$];
  logic [1:0] q_k[$];
  string      q_tag[$];

  always #5 clk = ~clk;

  qv_adder uut (.clk(clk), .rst(rst), .a(a), .b(b), .s(s), .k(k));

  // Independent list of carrying pairs (R5).
  function automatic bit carries(input int x, input int y);
    return (x == 1 && y == 3) || (x == 2 && y == 2) || (x == 2 && y == 3) ||
           (x == 3 && y == 1) || (x == 3 && y == 2) || (x == 3 && y == 3);
  endfunction

  // Driver: apply operands at the falling edge and queue the expected result.
  task automatic drive(input int x, input int y, input bit r, input string tag);
    @(negedge clk);
    rst = r;
    a   = 2'(x);
    b   = 2'(y);
    if (r) begin
      q_s.push_back(2'd0);
      q_k.push_back(2'd0);
    end else begin
      q_s.push_back(2'((x + y) % 4));
      q_k.push_back(2'((x + y) / 4));
    end
    q_tag.push_back(tag);
  endtask

  // Monitor: compare shortly after each rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q_s.size() > 0) begin
        logic [1:0] es, ek;
        string      t;
        es = q_s.pop_front();
        ek = q_k.pop_front();
        t  = q_tag.pop_front();
        checks++;
        if (s !== es || k !== ek) begin
          fails++;
          $display("FAIL %s: a=%0d b=%0d s=%0d k=%0d expected s=%0d k=%0d",
                   t, a, b, s, k, es, ek);
        end
        checks++;
        if (k > 2'd1) begin
          fails++;
          $display("FAIL R3: carry %0d expected at most 1", k);
        end
      end
    end
  end

  initial begin
    // R7: reset held with the largest operands must keep both digits at zero.
    drive(3, 3, 1'b1, "R7 reset");
    drive(3, 3, 1'b1, "R7 reset");

    // R1, R2, R4, R6: all 16 codes walked so each literal and product term leads once.
    for (int x = 0; x < 4; x++) begin
      for (int y = 0; y < 4; y++) begin
        drive(x, y, 1'b0, "R4 exhaustive");
      end
    end

    // R8: corner pairs on their own.
    drive(3, 3, 1'b0, "R8 3+3");
    drive(2, 2, 1'b0, "R8 2+2");
    drive(0, 0, 1'b0, "R8 0+0");

    // R7: reset in the middle of operation, then recovery.
    drive(3, 3, 1'b1, "R7 mid reset");
    drive(3, 3, 1'b0, "R6 after reset");
    drive(1, 2, 1'b0, "R6 next");
    repeat (3) @(negedge clk);

    // R5: carry set exactly on the six listed pairs.
    for (int x = 0; x < 4; x++) begin
      for (int y = 0; y < 4; y++) begin
        @(negedge clk);
        a = 2'(x);
        b = 2'(y);
        @(posedge clk);
        #2;
        checks++;
        if ((k == 2'd1) != carries(x, y)) begin
          fails++;
          $display("FAIL R5: a=%0d b=%0d k=%0d expected %0d", x, y, k, carries(x, y));
        end
      end
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  // Watchdog
  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule